// File: doc/BRIEF.md
# Phase-Change Memory Array Controller

This block sequences word accesses to a resistive phase-change cell array of 256 rows by 256 columns. The columns form 16 groups of 16, and each group has one sense amplifier and one write driver per column. A request carries a 12-bit word address. The low 8 bits pick the row and the upper 4 bits pick the same column inside every group, so each access moves one bit per group. The analog array, the bias generators and the sense amplifiers sit outside the block. The controller drives them through digital strobes and reads back one sense bit per group.

The controller has two organisations. In single-ended mode a word is 16 bits, one per group. In differential mode a word is 8 bits, and each bit is held as a complementary pair in groups 2k and 2k+1. A write programs every selected cell with one of two pulses: a short reset pulse stores 0 and a longer set pulse stores 1. The selected columns are then discharged. A read first precharges the columns, then senses for one cycle, and returns the word with a one-cycle valid pulse. A new request is accepted only when the previous sequence has fully completed.

Top module: `pcm_array_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, req_ready is 1 and wdrv_en, dis_chg, pre_chg, sense_en and rd_valid are all 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the whole write or read sequence has ended.
- R3: During a sequence, row_sel equals address bits [7:0] and col_sel equals address bits [11:8] of the accepted request, and both stay constant.
- R4: In single-ended mode, write data bit g sets bias_set[g]. A 1 selects the set (crystallising) level and a 0 selects the reset (amorphising) level.
- R5: Write drivers turn on in the cycle after a write is accepted, all groups together. A group whose bias is set stays enabled for T_SET cycles (default 5). A group whose bias is reset stays enabled for T_RESET cycles (default 2).
- R6: When the longest pulse has ended, dis_chg is high for exactly T_DIS cycles (default 2), and req_ready returns in the next cycle.
- R7: A read drives no write driver. pre_chg is high for T_PRE cycles (default 2), starting in the cycle after acceptance, and is followed by exactly one cycle of sense_en.
- R8: sense_in is captured at the end of the sense_en cycle. rd_valid is high for exactly the following cycle, with rd_data holding the word. In single-ended mode rd_data[g] = sense_in[g], where a sense value of 1 means a low-resistance (set) cell, read as 1.
- R9: In differential mode, write data bit k (k < 8) drives bias_set[2k] = bit and bias_set[2k+1] = inverted bit. Write data bits 15:8 are ignored.
- R10: In differential mode, rd_data[k] = sense_in[2k] AND NOT sense_in[2k+1], and rd_data[15:8] is 0. A pair read with equal values therefore returns 0.
- R11: mode_diff is sampled only when a request is accepted. Changing it during a sequence does not alter that sequence.
- R12: In any cycle at most one of these is active: any write driver, dis_chg, pre_chg, sense_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_diff | input | 1 | 1 = differential organisation, 0 = single-ended |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address: [7:0] row, [11:8] column in group |
| req_wdata | input | 16 | Write data (bits 7:0 used in differential mode) |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 16 | Read data word |
| row_sel | output | 8 | Selected row |
| col_sel | output | 4 | Selected column inside every group |
| wdrv_en | output | 16 | Write driver enable per group (selected column) |
| bias_set | output | 16 | Per-group drive level: 1 = set, 0 = reset |
| dis_chg | output | 1 | Column discharge strobe |
| pre_chg | output | 1 | Column precharge strobe |
| sense_en | output | 1 | Sense amplifier sample strobe |
| sense_in | input | 16 | Sense amplifier outputs, one per group |

## Verification
The differential compare rule is the hardest case to reach, because through the ports a write always stores a proper complementary pair. Only a broken pair shows whether the read really compares both cells. The bench therefore holds the cell array in its own model. After a differential write it forces two pairs to equal values inside that model (both cells 1, and both cells 0) and expects those bits to read back as 0. Mode changes in the middle of a sequence come from flipping mode_diff in the cycle after acceptance. Every cycle is compared against a behavioural timing model.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WRITE = 3'd1,
    PH_DISCH = 3'd2,
    PH_PRECH = 3'd3,
    PH_SENSE = 3'd4
  } phase_e;

  // Length of the write window: the longest pulse among the groups in use.
  function automatic int write_window(input logic any_set, input logic any_reset,
                                      input int t_set, input int t_reset);
    int w;
    w = 0;
    if (any_set && t_set > w) w = t_set;
    if (any_reset && t_reset > w) w = t_reset;
    return w;
  endfunction

  // Differential decision: the true cell must conduct and its partner must not.
  function automatic logic pair_decide(input logic s_true, input logic s_comp);
    return s_true & ~s_comp;
  endfunction

endpackage

// File: rtl/pcm_seq.sv
module pcm_seq
  import pcm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_DIS = 2,
  parameter int T_PRE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             start_rd,
  input  logic [CNT_W-1:0] wr_len,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             idle,
  output logic             sense_evt
);
  localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(T_DIS - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(T_PRE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start_wr)      phase <= PH_WRITE;
          else if (start_rd) phase <= PH_PRECH;
        end
        PH_WRITE: begin
          if (cnt == wr_len - 1'b1) begin
            phase <= PH_DISCH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DISCH: begin
          if (cnt == DIS_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_PRECH: begin
          if (cnt == PRE_LAST) begin
            phase <= PH_SENSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SENSE: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign idle      = (phase == PH_IDLE);
  assign sense_evt = (phase == PH_SENSE);

endmodule

// File: rtl/pcm_wr_map.sv
module pcm_wr_map #(
  parameter int GROUPS = 16
) (
  input  logic              diff,
  input  logic [GROUPS-1:0] wdata,
  output logic [GROUPS-1:0] bias
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int BIT = g / 2;
    if ((g % 2) == 0) begin : g_true
      assign bias[g] = diff ? wdata[BIT] : wdata[g];
    end else begin : g_comp
      assign bias[g] = diff ? ~wdata[BIT] : wdata[g];
    end
  end
endmodule

// File: rtl/pcm_rd_map.sv
module pcm_rd_map
  import pcm_pkg::*;
#(
  parameter int GROUPS = 16
) (
  input  logic              diff,
  input  logic [GROUPS-1:0] sense,
  output logic [GROUPS-1:0] data
);
  localparam int HALF = GROUPS / 2;

  for (genvar g = 0; g < GROUPS; g++) begin : g_bit
    if (g < HALF) begin : g_low
      assign data[g] = diff ? pair_decide(sense[2*g], sense[2*g+1]) : sense[g];
    end else begin : g_high
      assign data[g] = diff ? 1'b0 : sense[g];
    end
  end
endmodule

// File: rtl/pcm_drv_gen.sv
module pcm_drv_gen
  import pcm_pkg::*;
#(
  parameter int GROUPS  = 16,
  parameter int CNT_W   = 8,
  parameter int T_SET   = 5,
  parameter int T_RESET = 2
) (
  input  logic              in_write,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [GROUPS-1:0] bias,
  output logic [GROUPS-1:0] wdrv_en,
  output logic [CNT_W-1:0]  wr_len
);
  localparam logic [CNT_W-1:0] LEN_SET = CNT_W'(T_SET);
  localparam logic [CNT_W-1:0] LEN_RST = CNT_W'(T_RESET);

  for (genvar g = 0; g < GROUPS; g++) begin : g_drv
    logic [CNT_W-1:0] len_g;
    assign len_g      = bias[g] ? LEN_SET : LEN_RST;
    assign wdrv_en[g] = in_write && (cnt < len_g);
  end

  assign wr_len = CNT_W'(write_window(|bias, ~&bias, T_SET, T_RESET));
endmodule

// File: rtl/pcm_array_ctrl.sv
module pcm_array_ctrl
  import pcm_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int COL_W   = 4,
  parameter int GROUPS  = 16,
  parameter int T_RESET = 2,
  parameter int T_SET   = 5,
  parameter int T_DIS   = 2,
  parameter int T_PRE   = 2,
  parameter int CNT_W   = 8,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_diff,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [GROUPS-1:0] req_wdata,
  output logic              rd_valid,
  output logic [GROUPS-1:0] rd_data,
  output logic [ROW_W-1:0]  row_sel,
  output logic [COL_W-1:0]  col_sel,
  output logic [GROUPS-1:0] wdrv_en,
  output logic [GROUPS-1:0] bias_set,
  output logic              dis_chg,
  output logic              pre_chg,
  output logic              sense_en,
  input  logic [GROUPS-1:0] sense_in
);
  // Named internal events, also observed by the bound checker.
  logic              accept;
  logic              diff_q;
  logic              sense_evt;
  logic              idle;
  logic [ADDR_W-1:0] addr_q;
  logic [GROUPS-1:0] bias_q;
  logic [GROUPS-1:0] bias_next;
  logic [GROUPS-1:0] rd_word;
  logic [CNT_W-1:0]  wr_len;
  logic [CNT_W-1:0]  cnt;
  phase_e            phase;

  assign accept = req_valid && idle;

  pcm_wr_map #(.GROUPS(GROUPS)) u_wr_map (
    .diff  (mode_diff),
    .wdata (req_wdata),
    .bias  (bias_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      diff_q <= 1'b0;
      bias_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      diff_q <= mode_diff;
      bias_q <= bias_next;
    end
  end

  pcm_seq #(.CNT_W(CNT_W), .T_DIS(T_DIS), .T_PRE(T_PRE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_wr  (accept && req_we),
    .start_rd  (accept && !req_we),
    .wr_len    (wr_len),
    .phase     (phase),
    .cnt       (cnt),
    .idle      (idle),
    .sense_evt (sense_evt)
  );

  pcm_drv_gen #(.GROUPS(GROUPS), .CNT_W(CNT_W), .T_SET(T_SET), .T_RESET(T_RESET)) u_drv (
    .in_write (phase == PH_WRITE),
    .cnt      (cnt),
    .bias     (bias_q),
    .wdrv_en  (wdrv_en),
    .wr_len   (wr_len)
  );

  pcm_rd_map #(.GROUPS(GROUPS)) u_rd_map (
    .diff  (diff_q),
    .sense (sense_in),
    .data  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sense_evt;
      if (sense_evt) rd_data <= rd_word;
    end
  end

  assign req_ready = idle;
  assign row_sel   = addr_q[ROW_W-1:0];
  assign col_sel   = addr_q[ADDR_W-1:ROW_W];
  assign bias_set  = bias_q;
  assign dis_chg   = (phase == PH_DISCH);
  assign pre_chg   = (phase == PH_PRECH);
  assign sense_en  = sense_evt;

endmodule

// File: rtl/pcm_ctrl_chk.sv
module pcm_ctrl_chk #(
  parameter int GROUPS  = 16,
  parameter int ROW_W   = 8,
  parameter int COL_W   = 4,
  parameter int T_SET   = 5,
  parameter int T_RESET = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [GROUPS-1:0] wdrv_en,
  input logic [GROUPS-1:0] bias_set,
  input logic              dis_chg,
  input logic              pre_chg,
  input logic              sense_en,
  input logic              rd_valid,
  input logic [GROUPS-1:0] rd_data,
  input logic [ROW_W-1:0]  row_sel,
  input logic [COL_W-1:0]  col_sel,
  input logic              diff_q
);
  localparam int HALF = GROUPS / 2;
  localparam logic [7:0] LEN_SET = 8'(T_SET);
  localparam logic [7:0] LEN_RST = 8'(T_RESET);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(row_sel) && $stable(col_sel)));

  assert_discharge_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_chg) |-> $past(|wdrv_en));

  assert_sense_after_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_en) |-> $past(pre_chg));

  assert_valid_after_sense_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |=> (rd_valid && !sense_en));

  assert_valid_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(sense_en));

  assert_diff_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && diff_q) |-> ((rd_data >> HALF) == '0));

  assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|wdrv_en, dis_chg, pre_chg, sense_en}));

  // Per-group pulse length, measured with a counter rather than a long $past.
  for (genvar g = 0; g < GROUPS; g++) begin : g_pulse
    logic [7:0] run;
    always_ff @(posedge clk) begin
      if (!rst_n)          run <= '0;
      else if (wdrv_en[g]) run <= run + 8'd1;
      else                 run <= '0;
    end

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdrv_en[g] && $past(wdrv_en[g])) |-> (run == ($past(bias_set[g]) ? LEN_SET : LEN_RST)));
  end
endmodule

bind pcm_array_ctrl pcm_ctrl_chk #(
  .GROUPS(GROUPS), .ROW_W(ROW_W), .COL_W(COL_W), .T_SET(T_SET), .T_RESET(T_RESET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wdrv_en   (wdrv_en),
  .bias_set  (bias_set),
  .dis_chg   (dis_chg),
  .pre_chg   (pre_chg),
  .sense_en  (sense_en),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .row_sel   (row_sel),
  .col_sel   (col_sel),
  .diff_q    (diff_q)
);

// File: tb/tb_pcm_array_ctrl.sv
module tb_pcm_array_ctrl;
  localparam int TS = 5;
  localparam int TR = 2;
  localparam int TD = 2;
  localparam int TP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_diff = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] sense_in = '0;
  logic        req_ready, rd_valid, dis_chg, pre_chg, sense_en;
  logic [15:0] rd_data, wdrv_en, bias_set;
  logic [7:0]  row_sel;
  logic [3:0]  col_sel;

  always #2.5 clk = ~clk;

  pcm_array_ctrl #(.T_RESET(TR), .T_SET(TS), .T_DIS(TD), .T_PRE(TP)) dut (
    .clk(clk), .rst_n(rst_n), .mode_diff(mode_diff), .req_valid(req_valid),
    .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .row_sel(row_sel), .col_sel(col_sel),
    .wdrv_en(wdrv_en), .bias_set(bias_set), .dis_chg(dis_chg), .pre_chg(pre_chg),
    .sense_en(sense_en), .sense_in(sense_in)
  );

  // Behavioural cell array and expected words.
  logic        cells [int];
  logic [15:0] shadow [int];

  int          vectors = 0;
  int          miscompares = 0;
  bit          started = 0;
  bit          done = 0;

  // Reference timing model: 0 idle, 1 write, 2 discharge, 3 precharge, 4 sense.
  int          m_phase, m_cnt, m_len, m_addr;
  logic [15:0] m_bias;
  bit          m_diff, m_acc, m_rdv;
  logic [15:0] m_rdata;

  function automatic int cell_idx(input int row, input int grp, input int col);
    return row * 256 + grp * 16 + col;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_len = 0; m_addr = 0;
      m_bias = '0; m_diff = 0; m_acc = 0; m_rdv = 0; m_rdata = '0;
    end else begin
      m_acc = 0;
      m_rdv = 0;
      for (int g = 0; g < 16; g++)
        if (wdrv_en[g]) cells[cell_idx(int'(row_sel), g, int'(col_sel))] = bias_set[g];
      case (m_phase)
        0: if (req_valid) begin
          m_acc  = 1;
          m_addr = int'(req_addr);
          m_diff = mode_diff;
          m_cnt  = 0;
          if (req_we) begin
            if (m_diff) begin
              for (int k = 0; k < 8; k++) begin
                m_bias[2*k]   = req_wdata[k];
                m_bias[2*k+1] = ~req_wdata[k];
              end
              shadow[m_addr] = {8'h00, req_wdata[7:0]};
            end else begin
              m_bias = req_wdata;
              shadow[m_addr] = req_wdata;
            end
            m_len = 0;
            for (int g = 0; g < 16; g++) begin
              if (m_bias[g] && TS > m_len) m_len = TS;
              if (!m_bias[g] && TR > m_len) m_len = TR;
            end
            m_phase = 1;
          end else begin
            m_phase = 3;
          end
        end
        1: begin m_cnt++; if (m_cnt == m_len) begin m_phase = 2; m_cnt = 0; end end
        2: begin m_cnt++; if (m_cnt == TD) begin m_phase = 0; m_cnt = 0; end end
        3: begin m_cnt++; if (m_cnt == TP) begin m_phase = 4; m_cnt = 0; end end
        default: begin
          m_phase = 0;
          m_rdv   = 1;
          m_rdata = shadow.exists(m_addr) ? shadow[m_addr] : 16'h0000;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Compare every cycle away from the clock edge, then present the cells to the sense inputs.
  always @(negedge clk) begin
    if (started && !done) begin
      logic [15:0] exp_en;
      string tg;
      vectors++;
      tg = rst_n ? "R2 ready" : "R1 reset ready";
      chk(req_ready == (m_phase == 0), tg, 32'(req_ready), 32'(m_phase == 0));
      for (int g = 0; g < 16; g++)
        exp_en[g] = (m_phase == 1) && (m_cnt < (m_bias[g] ? TS : TR));
      chk(wdrv_en == exp_en, rst_n ? "R5 drivers" : "R1 drivers", 32'(wdrv_en), 32'(exp_en));
      chk((bias_set & exp_en) == (m_bias & exp_en), m_diff ? "R9 diff bias" : "R4 bias",
          32'(bias_set & exp_en), 32'(m_bias & exp_en));
      chk(dis_chg == (m_phase == 2), rst_n ? "R6 discharge" : "R1 discharge",
          32'(dis_chg), 32'(m_phase == 2));
      chk(pre_chg == (m_phase == 3), rst_n ? "R7 precharge" : "R1 precharge",
          32'(pre_chg), 32'(m_phase == 3));
      chk(sense_en == (m_phase == 4), rst_n ? "R7 sense" : "R1 sense",
          32'(sense_en), 32'(m_phase == 4));
      chk(rd_valid == m_rdv, rst_n ? "R8 rd_valid" : "R1 rd_valid", 32'(rd_valid), 32'(m_rdv));
      if (m_rdv)
        chk(rd_data == m_rdata, m_diff ? "R10 diff read" : "R8 read", 32'(rd_data), 32'(m_rdata));
      if (m_phase != 0)
        chk({col_sel, row_sel} == 12'(m_addr), "R3 address", 32'({col_sel, row_sel}), 32'(m_addr));
    end
    for (int g = 0; g < 16; g++) begin
      int ix;
      ix = cell_idx(int'(row_sel), g, int'(col_sel));
      sense_in[g] = cells.exists(ix) ? cells[ix] : 1'b0;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Issue one request; optionally flip mode_diff while it runs (R11).
  task automatic issue(input bit we, input int addr, input logic [15:0] data, input bit flip);
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = 12'(addr);
    req_wdata = data;
    forever begin
      @(negedge clk);
      if (m_acc) break;
    end
    req_valid = 1'b0;
    if (flip) mode_diff = ~mode_diff;
    while (m_phase != 0) @(negedge clk);
    if (flip) mode_diff = ~mode_diff;
  endtask

  function automatic logic [15:0] pattern(input int p, input int addr);
    bit odd;
    odd = ((addr & 1) ^ ((addr >> 8) & 1)) != 0;
    case (p)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return odd ? 16'h5555 : 16'hAAAA;
      default: return odd ? 16'hAAAA : 16'h5555;
    endcase
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // Four patterns in each mode (R4, R5, R6, R7, R8, R9, R10).
    for (int md = 0; md < 2; md++) begin
      mode_diff = md[0];
      shadow.delete();
      for (int p = 0; p < 4; p++) begin
        for (int i = 0; i < 48; i++) begin
          int a;
          a = (i * 331 + p * 1237) % 4096;
          issue(1'b1, a, pattern(p, a), 1'b0);
        end
        for (int i = 0; i < 48; i++) begin
          int a;
          a = (i * 331 + p * 1237) % 4096;
          issue(1'b0, a, 16'h0000, 1'b0);
        end
      end
    end
    // R11: mode flips during single-ended sequences have no effect.
    mode_diff = 1'b0;
    shadow.delete();
    issue(1'b1, 12'h123, 16'h1234, 1'b1);
    issue(1'b0, 12'h123, 16'h0000, 1'b1);
    // R10: broken pairs read as 0.
    mode_diff = 1'b1;
    issue(1'b1, 12'h9A7, 16'h00FF, 1'b0);
    cells[cell_idx(8'hA7, 0, 9)] = 1'b1;
    cells[cell_idx(8'hA7, 1, 9)] = 1'b1;
    cells[cell_idx(8'hA7, 2, 9)] = 1'b0;
    cells[cell_idx(8'hA7, 3, 9)] = 1'b0;
    shadow[12'h9A7] = 16'h00FC;
    issue(1'b0, 12'h9A7, 16'h0000, 1'b0);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule